// File: doc/BRIEF.md
# Rotating-Parity Stripe Write Controller

This controller turns one logical block write into the physical column operations of a five-column striped array. Every stripe holds four data units and one parity unit. The parity unit moves one column to the left from each stripe to the next, and the pattern repeats every five stripes. The controller takes a logical unit number and a new data word. From these it works out the stripe, the column that holds the data unit and the column that holds the parity. It then carries out the small-write update: it fetches the old data and the old parity, and it writes back the new data and the refreshed parity.

The physical side is a single request/acknowledge channel. Each operation shows a column index, a stripe index, a read/write flag and a write word. The operation stays on the channel until it is acknowledged. For a read, the returned word is valid in the acknowledge cycle. The new parity is formed by XOR as the two reads come back, so the controller keeps no separate copies of the old values. The controller takes only one logical write at a time, and it signals completion with a one-cycle pulse.

Top module: `stripe_rmw_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `phy_req` and `done` are 0 and `req_ready` is 1.
- R2: A write is taken only on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 exactly when no operation is outstanding. A `req_valid` pulse while the controller is busy starts nothing and leaves the operation sequence unchanged.
- R3: Every physical operation of a logical write to unit L carries `phy_stripe` = L / 4, with integer division.
- R4: Columns are numbered 0 to 4. The parity column of stripe S is 4 - (S mod 5). Stripe 0 therefore keeps its parity in column 4 and stripe 1 in column 3.
- R5: Data units fill the non-parity columns of a stripe in ascending column order. The data column is (L mod 4), plus one when that value is at or above the parity column. For example, unit 7 maps to column 4 of stripe 1.
- R6: Each logical write produces exactly four operations in this order: read the data column, read the parity column, write the data column, write the parity column. `phy_we` is 0 for the reads and 1 for the writes.
- R7: The data-column write carries the new data word that was taken with the request.
- R8: The parity write carries old data XOR new data XOR old parity. The old data and old parity are the `phy_rdata` words returned with the two read acknowledges. As a result, every stripe's XOR over all five columns stays zero.
- R9: An operation holds `phy_req`, the column, the stripe, the flag and the write word steady until the edge that samples `phy_ack`. The next operation appears in the cycle right after that edge.
- R10: `done` is high for exactly one cycle: the cycle after the parity write is acknowledged. In that same cycle `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Logical write request |
| req_lba | input | LBA_W | Logical data unit number |
| req_data | input | DATA_W | New data word |
| req_ready | output | 1 | Idle, a request can be taken |
| phy_req | output | 1 | Physical operation pending |
| phy_col | output | COL_W | Target column, 0 to 4 |
| phy_stripe | output | LBA_W | Target stripe index |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_wdata | output | DATA_W | Word to write |
| phy_ack | input | 1 | Operation completed this cycle |
| phy_rdata | input | DATA_W | Read word, valid with `phy_ack` |
| done | output | 1 | Logical write finished, one-cycle pulse |

## Verification
If the sequencer takes a wrong step, the fault appears on the physical channel in the very next cycle. The column, flag or write word then stops matching the cycle-by-cycle model, even when the acknowledge arrives with zero latency. An error in the parity accumulator stays hidden through both reads. It shows up only in the fourth operation's write word, and it also leaves a stripe whose XOR is no longer zero, which the final sweep over the whole array detects. A mapping fault reaches the ports in the first cycle after acceptance, and the rotation is exercised across all five parity positions.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

  // Steps of the small-write update. The order is part of the behaviour.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_OLD = 3'd1,
    ST_RD_PAR = 3'd2,
    ST_WR_DAT = 3'd3,
    ST_WR_PAR = 3'd4
  } rmw_state_e;

endpackage

// File: rtl/stripe_addr_map.sv
// Logical unit -> stripe, parity column and data column (combinational).
module stripe_addr_map #(
  parameter int NCOL     = 5,
  parameter int LBA_W    = 16,
  parameter int COL_W    = 3,
  parameter int STRIPE_W = 16
) (
  input  logic [LBA_W-1:0]    lba,
  output logic [STRIPE_W-1:0] stripe,
  output logic [COL_W-1:0]    pcol,
  output logic [COL_W-1:0]    dcol
);
  localparam int DPS = NCOL - 1;  // data units per stripe

  function automatic logic [STRIPE_W-1:0] f_stripe(input logic [LBA_W-1:0] l);
    return STRIPE_W'(l / LBA_W'(DPS));
  endfunction

  // Parity starts in the last column and moves left by one per stripe.
  function automatic logic [COL_W-1:0] f_pcol(input logic [STRIPE_W-1:0] s);
    logic [COL_W-1:0] rot;
    rot = COL_W'(s % STRIPE_W'(NCOL));
    return COL_W'(NCOL - 1) - rot;
  endfunction

  // The slot within the stripe skips over the parity column.
  function automatic logic [COL_W-1:0] f_dcol(input logic [LBA_W-1:0] l,
                                               input logic [COL_W-1:0] p);
    logic [COL_W-1:0] slot;
    slot = COL_W'(l % LBA_W'(DPS));
    return (slot >= p) ? slot + COL_W'(1) : slot;
  endfunction

  always_comb begin
    stripe = f_stripe(lba);
    pcol   = f_pcol(stripe);
    dcol   = f_dcol(lba, pcol);
  end

endmodule

// File: rtl/stripe_rmw_seq.sv
// Four-step read-modify-write sequencer with a running XOR parity.
module stripe_rmw_seq
  import stripe_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int COL_W    = 3,
  parameter int STRIPE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [STRIPE_W-1:0] start_stripe,
  input  logic [COL_W-1:0]    start_dcol,
  input  logic [COL_W-1:0]    start_pcol,
  input  logic [DATA_W-1:0]   start_data,
  input  logic                phy_ack,
  input  logic [DATA_W-1:0]   phy_rdata,
  output logic                idle,
  output logic                phy_req,
  output logic [COL_W-1:0]    phy_col,
  output logic [STRIPE_W-1:0] phy_stripe,
  output logic                phy_we,
  output logic [DATA_W-1:0]   phy_wdata,
  output logic                op_fire,
  output logic                done
);
  rmw_state_e          state_q, state_d;
  logic [STRIPE_W-1:0] stripe_q;
  logic [COL_W-1:0]    dcol_q, pcol_q;
  logic [DATA_W-1:0]   new_q, par_q;
  logic                done_q;

  function automatic rmw_state_e f_after(input rmw_state_e s);
    case (s)
      ST_RD_OLD: return ST_RD_PAR;
      ST_RD_PAR: return ST_WR_DAT;
      ST_WR_DAT: return ST_WR_PAR;
      default:   return ST_IDLE;
    endcase
  endfunction

  function automatic logic f_is_write(input rmw_state_e s);
    return (s == ST_WR_DAT) || (s == ST_WR_PAR);
  endfunction

  function automatic logic f_on_parity(input rmw_state_e s);
    return (s == ST_RD_PAR) || (s == ST_WR_PAR);
  endfunction

  assign op_fire = (state_q != ST_IDLE) && phy_ack;

  always_comb begin
    if (state_q == ST_IDLE) state_d = start ? ST_RD_OLD : ST_IDLE;
    else if (phy_ack)       state_d = f_after(state_q);
    else                    state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      stripe_q <= '0;
      dcol_q   <= '0;
      pcol_q   <= '0;
      new_q    <= '0;
      par_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= op_fire && (state_q == ST_WR_PAR);
      if (state_q == ST_IDLE && start) begin
        stripe_q <= start_stripe;
        dcol_q   <= start_dcol;
        pcol_q   <= start_pcol;
        new_q    <= start_data;
        par_q    <= start_data;      // parity accumulator seeded with new data
      end else if (op_fire && !f_is_write(state_q)) begin
        par_q    <= par_q ^ phy_rdata;  // fold in old data, then old parity
      end
    end
  end

  assign idle       = (state_q == ST_IDLE);
  assign phy_req    = (state_q != ST_IDLE);
  assign phy_col    = f_on_parity(state_q) ? pcol_q : dcol_q;
  assign phy_stripe = stripe_q;
  assign phy_we     = f_is_write(state_q);
  assign phy_wdata  = (state_q == ST_WR_PAR) ? par_q : new_q;
  assign done       = done_q;

endmodule

// File: rtl/stripe_rmw_ctrl.sv
// Top: request port, address map and read-modify-write sequencer.
module stripe_rmw_ctrl #(
  parameter int DATA_W = 32,
  parameter int LBA_W  = 16,
  parameter int NCOL   = 5,
  parameter int COL_W  = $clog2(NCOL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LBA_W-1:0]  req_lba,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              phy_req,
  output logic [COL_W-1:0]  phy_col,
  output logic [LBA_W-1:0]  phy_stripe,
  output logic              phy_we,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              done
);
  localparam int STRIPE_W = LBA_W;

  // Named internal events, brought out for the checker.
  logic                accept;
  logic                op_fire;
  logic                seq_idle;
  logic [STRIPE_W-1:0] map_stripe;
  logic [COL_W-1:0]    map_pcol, map_dcol;

  stripe_addr_map #(
    .NCOL(NCOL), .LBA_W(LBA_W), .COL_W(COL_W), .STRIPE_W(STRIPE_W)
  ) u_map (
    .lba    (req_lba),
    .stripe (map_stripe),
    .pcol   (map_pcol),
    .dcol   (map_dcol)
  );

  assign accept    = req_valid && seq_idle;
  assign req_ready = seq_idle;

  stripe_rmw_seq #(
    .DATA_W(DATA_W), .COL_W(COL_W), .STRIPE_W(STRIPE_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .start_stripe (map_stripe),
    .start_dcol   (map_dcol),
    .start_pcol   (map_pcol),
    .start_data   (req_data),
    .phy_ack      (phy_ack),
    .phy_rdata    (phy_rdata),
    .idle         (seq_idle),
    .phy_req      (phy_req),
    .phy_col      (phy_col),
    .phy_stripe   (phy_stripe),
    .phy_we       (phy_we),
    .phy_wdata    (phy_wdata),
    .op_fire      (op_fire),
    .done         (done)
  );

endmodule

// File: rtl/stripe_rmw_chk.sv
// Property checker, bound to the top module.
module stripe_rmw_chk #(
  parameter int DATA_W   = 32,
  parameter int NCOL     = 5,
  parameter int COL_W    = 3,
  parameter int STRIPE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              phy_req,
  input logic [COL_W-1:0]  phy_col,
  input logic [STRIPE_W-1:0] phy_stripe,
  input logic              phy_we,
  input logic [DATA_W-1:0] phy_wdata,
  input logic              done,
  input logic              accept,
  input logic              op_fire,
  input logic [COL_W-1:0]  map_pcol,
  input logic [COL_W-1:0]  map_dcol
);

  AST_OP_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !op_fire |=> phy_req && $stable(phy_col) && $stable(phy_stripe)
                            && $stable(phy_we) && $stable(phy_wdata)); // R9

  AST_FIRST_OP_READS_DATA_COL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> phy_req && !phy_we && (phy_col == $past(map_dcol))); // R5

  AST_MAP_COLUMNS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (map_pcol < COL_W'(NCOL)) && (map_dcol < COL_W'(NCOL)) && (map_dcol != map_pcol)); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> !req_ready); // R2

  AST_WRITES_AFTER_ACKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_we && $past(phy_req && !phy_we) |-> $past(op_fire)); // R6

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AFTER_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_fire && phy_we) && req_ready); // R10

endmodule

bind stripe_rmw_ctrl stripe_rmw_chk #(
  .DATA_W(DATA_W), .NCOL(NCOL), .COL_W(COL_W), .STRIPE_W(LBA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .phy_req    (phy_req),
  .phy_col    (phy_col),
  .phy_stripe (phy_stripe),
  .phy_we     (phy_we),
  .phy_wdata  (phy_wdata),
  .done       (done),
  .accept     (accept),
  .op_fire    (op_fire),
  .map_pcol   (map_pcol),
  .map_dcol   (map_dcol)
);

// File: tb/stripe_rmw_ctrl_bench.sv
`timescale 1ns/1ps
module stripe_rmw_ctrl_bench;
  localparam int DW = 32;
  localparam int LW = 16;
  localparam int NC = 5;
  localparam int CW = 3;
  localparam int NSTR = 16;   // stripes touched: units 0..63
  localparam int NPLAN = 90;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_lba = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready;
  logic          phy_req;
  logic [CW-1:0] phy_col;
  logic [LW-1:0] phy_stripe;
  logic          phy_we;
  logic [DW-1:0] phy_wdata;
  logic          phy_ack = 1'b0;
  logic [DW-1:0] phy_rdata = '0;
  logic          done;

  always #2.5 clk = ~clk;  // 200 MHz

  stripe_rmw_ctrl u_stripe_rmw_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lba(req_lba),
    .req_data(req_data), .req_ready(req_ready), .phy_req(phy_req),
    .phy_col(phy_col), .phy_stripe(phy_stripe), .phy_we(phy_we),
    .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
    .done(done)
  );

  typedef struct packed {
    int          col;
    int          str;
    bit          we;
    logic [31:0] wd;
  } op_t;

  op_t         q[$];
  logic [31:0] disk [NC][NSTR];
  int          checks = 0;
  int          failures = 0;
  int unsigned rnd = 32'h1234_5678;
  int          plan_lba [NPLAN];
  logic [31:0] plan_dat [NPLAN];

  function automatic int unsigned next_rnd(input int unsigned r);
    return r * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // Reference mapping by walking the columns of the stripe.
  task automatic push_write(input int lba, input logic [31:0] d);
    int s, p, k, dc, n;
    logic [31:0] od, op;
    s = lba / 4;
    p = (NC - 1) - (s % NC);
    k = lba % 4;
    n = 0;
    dc = -1;
    for (int c = 0; c < NC; c++) begin
      if (c != p) begin
        if (n == k) dc = c;
        n++;
      end
    end
    od = disk[dc][s];
    op = disk[p][s];
    q.push_back('{col: dc, str: s, we: 1'b0, wd: 32'h0});
    q.push_back('{col: p,  str: s, we: 1'b0, wd: 32'h0});
    q.push_back('{col: dc, str: s, we: 1'b1, wd: d});
    q.push_back('{col: p,  str: s, we: 1'b1, wd: od ^ d ^ op});
  endtask

  initial begin
    int pi, gap, lat_tgt, lat_cnt, cyc, idx;
    bit done_exp, poke_pending, issued;
    op_t f;
    logic [31:0] x;

    // Initial array contents with consistent parity (XOR over a stripe = 0).
    for (int s = 0; s < NSTR; s++) begin
      x = '0;
      for (int c = 0; c < NC; c++) begin
        if (c != (NC - 1) - (s % NC)) begin
          disk[c][s] = 32'hA500_0000 ^ (c << 12) ^ (s * 32'h0101);
          x ^= disk[c][s];
        end
      end
      disk[(NC - 1) - (s % NC)][s] = x;
    end

    // Plan: every unit 0..39 in order, then random units, then one unit repeated.
    for (int i = 0; i < 40; i++) begin
      plan_lba[i] = i;
      plan_dat[i] = 32'h1000_0000 + i * 3;
    end
    for (int i = 40; i < 84; i++) begin
      rnd = next_rnd(rnd);
      plan_lba[i] = (rnd >> 10) % 64;
      rnd = next_rnd(rnd);
      plan_dat[i] = (i % 11 == 0) ? 32'hFFFF_FFFF : (i % 13 == 0) ? 32'h0 : rnd;
    end
    for (int i = 84; i < NPLAN; i++) begin
      plan_lba[i] = 9;
      plan_dat[i] = 32'hC0DE_0000 + i;
    end

    // R1: outputs while reset is held.
    repeat (3) @(negedge clk);
    chk(phy_req == 1'b0, "R1 phy_req in reset", 64'(phy_req), 64'd0);
    chk(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R1 req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phy_req == 1'b0 && done == 1'b0 && req_ready == 1'b1,
        "R1 state after reset", {61'd0, phy_req, done, req_ready}, 64'd1);

    pi = 0; gap = 0; lat_tgt = 0; lat_cnt = 0; cyc = 0;
    done_exp = 1'b0; poke_pending = 1'b0;
    while (pi < NPLAN || q.size() != 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", 64'(cyc), 64'd0);
        break;
      end
      // Retire the operation acknowledged at the last edge.
      done_exp = 1'b0;
      if (phy_ack) begin
        void'(q.pop_front());
        phy_ack = 1'b0;
        if (q.size() == 0) done_exp = 1'b1;
        rnd = next_rnd(rnd);
        lat_tgt = (rnd >> 16) % 4;
        lat_cnt = 0;
      end
      // Compare the ports with the model.
      chk(req_ready == (q.size() == 0), "R2 req_ready", 64'(req_ready), 64'(q.size() == 0));
      chk(done == done_exp, "R10 done pulse", 64'(done), 64'(done_exp));
      if (q.size() == 0) begin
        chk(phy_req == 1'b0, "R9 no op pending", 64'(phy_req), 64'd0);
      end else begin
        f = q[0];
        idx = 4 - q.size();
        chk(phy_req == 1'b1, "R9 op pending", 64'(phy_req), 64'd1);
        chk(int'(phy_stripe) == f.str, "R3 stripe", 64'(phy_stripe), 64'(f.str));
        if (idx == 0 || idx == 2)
          chk(int'(phy_col) == f.col, "R5 data column", 64'(phy_col), 64'(f.col));
        else
          chk(int'(phy_col) == f.col, "R4 parity column", 64'(phy_col), 64'(f.col));
        chk(phy_we == f.we, "R6 op order/flag", 64'(phy_we), 64'(f.we));
        if (idx == 2) chk(phy_wdata == f.wd, "R7 new data", 64'(phy_wdata), 64'(f.wd));
        if (idx == 3) chk(phy_wdata == f.wd, "R8 new parity", 64'(phy_wdata), 64'(f.wd));
        // Responder: variable latency, read data returned with the ack.
        if (lat_cnt >= lat_tgt) begin
          phy_ack = 1'b1;
          if (f.we) begin
            disk[f.col][f.str] = phy_wdata;
            phy_rdata = 32'hDEAD_BEEF;
          end else begin
            phy_rdata = disk[f.col][f.str];
          end
        end else begin
          lat_cnt++;
        end
      end
      // Stimulus.
      req_valid = 1'b0;
      issued = 1'b0;
      if (q.size() == 0 && pi < NPLAN) begin
        if (gap == 0) begin
          req_valid = 1'b1;
          req_lba = LW'(plan_lba[pi]);
          req_data = plan_dat[pi];
          push_write(plan_lba[pi], plan_dat[pi]);
          poke_pending = (pi % 3 == 0);
          rnd = next_rnd(rnd);
          gap = (rnd >> 20) % 3;
          lat_tgt = (rnd >> 8) % 4;
          lat_cnt = 0;
          pi++;
          issued = 1'b1;
        end else begin
          gap--;
        end
      end
      // R2: a request while busy must be ignored.
      if (!issued && poke_pending && q.size() >= 2) begin
        req_valid = 1'b1;
        req_lba = LW'((plan_lba[pi-1] + 17) % 64);
        req_data = ~plan_dat[pi-1];
        poke_pending = 1'b0;
      end
    end

    repeat (3) @(negedge clk);
    chk(phy_req == 1'b0 && req_ready == 1'b1, "R2 idle at end",
        {62'd0, phy_req, req_ready}, 64'd1);
    // R8: every stripe's XOR across the five columns is still zero.
    for (int s = 0; s < NSTR; s++) begin
      x = '0;
      for (int c = 0; c < NC; c++) x ^= disk[c][s];
      chk(x == 32'h0, "R8 stripe parity invariant", 64'(x), 64'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule